// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits beside an instruction sequencer and decides, once per instruction, whether the processor must break off and enter a service routine. It gathers five request lines: a non-maskable line that must show a rising edge and still be high, a restart line captured by a rising-edge latch, two level-sensitive restart lines, and a general request whose service instruction comes from outside. It holds a global enable flag, one mask bit per restart line and a serial-out bit, all loaded from a one-byte control write. A one-byte status view shows the masks, the enable flag, the pending restart requests and the serial input pin.

At each sample strobe, the controller registers the winner among the eligible requests. It presents the source code, the 16-bit service address and a flag that says the address must be supplied externally. The result stays until the sequencer pulses the accept strobe or the next sample strobe replaces it. Accepting any maskable request drops the global enable flag. Accepting the edge-latched line or the non-maskable line consumes that line's latch.

Top module: `ivc`

## Requirements
- R1: After reset the three mask bits are 1, the global enable flag is 0, both edge latches are clear, `ser_out` is 0 and `take_valid` is 0.
- R2: On a `mask_wr` cycle with `mask_wdata[3]` = 1, `mask_wdata[0]`, `[1]` and `[2]` load the masks of the low restart line, the high restart line and the edge restart line. A 1 masks the line. With bit 3 = 0 the masks keep their old value.
- R3: On a `mask_wr` cycle, `mask_wdata[4]` = 1 clears the edge latch and bit 5 has no effect. `ser_out` takes `mask_wdata[7]` only when `mask_wdata[6]` = 1 and otherwise holds its value.
- R4: `stat_rdata` is combinational, with this layout: bits 2:0 hold the masks in the R2 order, bit 3 the enable flag, bit 4 the low line level, bit 5 the high line level, bit 6 the edge latch and bit 7 `ser_in`.
- R5: A 0-to-1 step on `edge_irq_in` sets the edge latch on the following clock edge, and the latch stays set after the input falls. The low line, the high line and the general request are level sensitive and leave no record once they fall.
- R6: The non-maskable line wins only when its rising edge has been seen and the line is still high at the sample. It ignores the enable flag and every mask bit. A line held high after its acceptance does not win again.
- R7: A restart line is eligible only when its mask bit is 0 and the enable flag is 1. The general request needs only the enable flag.
- R8: Fixed priority, from highest to lowest: the non-maskable line, the edge line, the high line, the low line, then the general request.
- R9: `take_src` codes are 1 for non-maskable, 2 for edge, 3 for high, 4 for low, 5 for general and 0 for none. The addresses are 0024h, 003Ch, 0034h and 002Ch. The general request gives address 0000h with `take_ext` = 1.
- R10: Requests are judged only on a `sample_stb` cycle. The result appears on the `take_*` outputs one clock later and holds until the next sample or accept. A sample that finds nothing eligible gives `take_valid` = 0.
- R11: `en_stb` sets the enable flag and `dis_stb` clears it. Accepting any source other than the non-maskable line also clears it. Accepting the non-maskable line leaves it unchanged.
- R12: `accept_stb` while `take_valid` = 1 drops `take_valid` on the next clock. It clears the edge latch when the edge line was taken and the non-maskable latch when that line was taken. An accept cycle suppresses a sample in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_in | input | 1 | Non-maskable request, edge and level qualified |
| edge_irq_in | input | 1 | Restart request captured on a rising edge |
| hi_irq_in | input | 1 | Level restart request, middle priority |
| lo_irq_in | input | 1 | Level restart request, lowest restart priority |
| ext_irq_in | input | 1 | General request with externally supplied instruction |
| en_stb | input | 1 | Set global enable flag |
| dis_stb | input | 1 | Clear global enable flag |
| sample_stb | input | 1 | Last state of an instruction: judge requests |
| accept_stb | input | 1 | Sequencer takes the presented request |
| mask_wr | input | 1 | Control byte write strobe |
| mask_wdata | input | 8 | Control byte |
| ser_in | input | 1 | Serial input pin, shown in status |
| stat_rdata | output | 8 | Status byte |
| ser_out | output | 1 | Latched serial output bit |
| take_valid | output | 1 | A request is presented |
| take_src | output | 3 | Source code of the presented request |
| take_vector | output | 16 | Service address |
| take_ext | output | 1 | Service instruction must come from outside |

## Verification
The `take_*` results are due one clock after the `sample_stb` edge. The status byte follows a control write, enable strobe or accept on the next edge. An edge latch needs one edge to capture before a sample can see it. The bench drives inputs on the falling clock edge. Each sample strobe pushes an expected item into a queue, and a monitor pops that item on the falling edge after the sampling edge. Status, serial and accept effects are read on the falling edge right after the strobe's one active edge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam int unsigned VEC_W       = 16;
  localparam int unsigned CTRL_W      = 8;
  localparam int unsigned NUM_RESTART = 3;
  localparam int unsigned SLOT_STRIDE = 8;
  localparam int unsigned HALF_OFFSET = 4;

  // control byte field positions
  localparam int unsigned WB_MASK_LSB = 0;
  localparam int unsigned WB_MASK_EN  = 3;
  localparam int unsigned WB_EDGE_CLR = 4;
  localparam int unsigned WB_SPARE    = 5;
  localparam int unsigned WB_SER_EN   = 6;
  localparam int unsigned WB_SER_DAT  = 7;

  // restart slot numbers; address = slot * stride + half offset
  localparam int unsigned SLOT_NMI  = 4;
  localparam int unsigned SLOT_LO   = 5;
  localparam int unsigned SLOT_HI   = 6;
  localparam int unsigned SLOT_EDGE = 7;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_EDGE = 3'd2,
    SRC_HI   = 3'd3,
    SRC_LO   = 3'd4,
    SRC_EXT  = 3'd5
  } src_e;

  function automatic logic [VEC_W-1:0] half_slot_vector(input int unsigned slot);
    return VEC_W'(slot * SLOT_STRIDE + HALF_OFFSET);
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(input src_e s);
    case (s)
      SRC_NMI:  return half_slot_vector(SLOT_NMI);
      SRC_EDGE: return half_slot_vector(SLOT_EDGE);
      SRC_HI:   return half_slot_vector(SLOT_HI);
      SRC_LO:   return half_slot_vector(SLOT_LO);
      default:  return '0;
    endcase
  endfunction

  function automatic logic is_maskable(input src_e s);
    return (s != SRC_NONE) && (s != SRC_NMI);
  endfunction

  // restart index (0 = low, 1 = high, 2 = edge) to source code
  function automatic src_e restart_src(input int unsigned idx);
    case (idx)
      0:       return SRC_LO;
      1:       return SRC_HI;
      default: return SRC_EDGE;
    endcase
  endfunction

endpackage

// File: rtl/ivc_edge_cap.sv
module ivc_edge_cap #(
  parameter bit LEVEL_QUAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic clr,
  output logic flag,
  output logic rise
);

  logic prev_q;
  logic flag_q;
  logic hold;

  assign rise = din & ~prev_q;

  generate
    if (LEVEL_QUAL) begin : g_level
      assign hold = din;
    end else begin : g_sticky
      assign hold = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= din;
      flag_q <= rise | (flag_q & ~clr & hold);
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/ivc_ctrl_regs.sv
module ivc_ctrl_regs
  import ivc_pkg::*;
#(
  parameter int unsigned MASK_W = NUM_RESTART
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              en_stb,
  input  logic              dis_stb,
  input  logic              ie_kill,
  output logic [MASK_W-1:0] mask_q,
  output logic              ie_q,
  output logic              ser_q,
  output logic              edge_clr
);

  logic wdata_unused;
  assign wdata_unused = wr_data[WB_SPARE];

  logic load_mask;
  logic load_ser;
  assign load_mask = wr_en & wr_data[WB_MASK_EN];
  assign load_ser  = wr_en & wr_data[WB_SER_EN];
  assign edge_clr  = wr_en & wr_data[WB_EDGE_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
      ser_q  <= 1'b0;
    end else begin
      if (load_mask) mask_q <= wr_data[WB_MASK_LSB +: MASK_W];
      if (load_ser)  ser_q  <= wr_data[WB_SER_DAT];
      if (ie_kill)      ie_q <= 1'b0;
      else if (dis_stb) ie_q <= 1'b0;
      else if (en_stb)  ie_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int unsigned NR = NUM_RESTART
) (
  input  logic             nmi_ok,
  input  logic [NR-1:0]    restart_pend,
  input  logic [NR-1:0]    mask,
  input  logic             ie,
  input  logic             ext_lvl,
  output logic             hit,
  output src_e             src,
  output logic [VEC_W-1:0] vec,
  output logic             need_ext
);

  logic [NR-1:0] restart_ok;

  generate
    for (genvar i = 0; i < NR; i++) begin : g_gate
      assign restart_ok[i] = restart_pend[i] & ~mask[i] & ie;
    end
  endgenerate

  always_comb begin
    src = SRC_NONE;
    if (ext_lvl && ie) src = SRC_EXT;
    for (int i = 0; i < NR; i++) begin
      if (restart_ok[i]) src = restart_src(i);
    end
    if (nmi_ok) src = SRC_NMI;
  end

  assign hit      = (src != SRC_NONE);
  assign vec      = src_vector(src);
  assign need_ext = (src == SRC_EXT);

endmodule

// File: rtl/ivc.sv
module ivc
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              edge_irq_in,
  input  logic              hi_irq_in,
  input  logic              lo_irq_in,
  input  logic              ext_irq_in,
  input  logic              en_stb,
  input  logic              dis_stb,
  input  logic              sample_stb,
  input  logic              accept_stb,
  input  logic              mask_wr,
  input  logic [CTRL_W-1:0] mask_wdata,
  input  logic              ser_in,
  output logic [CTRL_W-1:0] stat_rdata,
  output logic              ser_out,
  output logic              take_valid,
  output logic [2:0]        take_src,
  output logic [VEC_W-1:0]  take_vector,
  output logic              take_ext
);

  // named internal events
  logic                   nmi_armed;
  logic                   nmi_rise;
  logic                   edge_pend;
  logic                   edge_rise;
  logic                   ie_q;
  logic [NUM_RESTART-1:0] mask_q;
  logic                   wr_edge_clr;
  logic                   accept_fire;
  logic                   sample_fire;
  logic                   accept_maskable;
  logic                   accept_nmi;
  logic                   accept_edge;

  logic                   arb_hit;
  src_e                   arb_src;
  logic [VEC_W-1:0]       arb_vec;
  logic                   arb_ext;

  logic                   valid_q;
  src_e                   src_q;
  logic [VEC_W-1:0]       vec_q;
  logic                   ext_q;

  assign accept_fire     = accept_stb & valid_q;
  assign sample_fire     = sample_stb & ~accept_stb;
  assign accept_maskable = accept_fire & is_maskable(src_q);
  assign accept_nmi      = accept_fire & (src_q == SRC_NMI);
  assign accept_edge     = accept_fire & (src_q == SRC_EDGE);

  ivc_edge_cap #(.LEVEL_QUAL(1'b1)) u_nmi_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (nmi_in),
    .clr  (accept_nmi),
    .flag (nmi_armed),
    .rise (nmi_rise)
  );

  ivc_edge_cap #(.LEVEL_QUAL(1'b0)) u_edge_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (edge_irq_in),
    .clr  (wr_edge_clr | accept_edge),
    .flag (edge_pend),
    .rise (edge_rise)
  );

  ivc_ctrl_regs #(.MASK_W(NUM_RESTART)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mask_wr),
    .wr_data (mask_wdata),
    .en_stb  (en_stb),
    .dis_stb (dis_stb),
    .ie_kill (accept_maskable),
    .mask_q  (mask_q),
    .ie_q    (ie_q),
    .ser_q   (ser_out),
    .edge_clr(wr_edge_clr)
  );

  logic rise_unused;
  assign rise_unused = nmi_rise ^ edge_rise;

  ivc_arbiter #(.NR(NUM_RESTART)) u_arb (
    .nmi_ok      (nmi_armed & nmi_in),
    .restart_pend({edge_pend, hi_irq_in, lo_irq_in}),
    .mask        (mask_q),
    .ie          (ie_q),
    .ext_lvl     (ext_irq_in),
    .hit         (arb_hit),
    .src         (arb_src),
    .vec         (arb_vec),
    .need_ext    (arb_ext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= SRC_NONE;
      vec_q   <= '0;
      ext_q   <= 1'b0;
    end else if (accept_fire) begin
      valid_q <= 1'b0;
      src_q   <= SRC_NONE;
      vec_q   <= '0;
      ext_q   <= 1'b0;
    end else if (sample_fire) begin
      valid_q <= arb_hit;
      src_q   <= arb_src;
      vec_q   <= arb_vec;
      ext_q   <= arb_ext;
    end
  end

  assign stat_rdata  = {ser_in, edge_pend, hi_irq_in, lo_irq_in, ie_q, mask_q};
  assign take_valid  = valid_q;
  assign take_src    = src_q;
  assign take_vector = vec_q;
  assign take_ext    = ext_q;

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   nmi_in,
  input logic                   sample_stb,
  input logic                   accept_stb,
  input logic                   mask_wr,
  input logic [CTRL_W-1:0]      mask_wdata,
  input logic                   take_valid,
  input logic [2:0]             take_src,
  input logic                   take_ext,
  input logic                   ie_q,
  input logic [NUM_RESTART-1:0] mask_q
);

  logic src_restart;
  assign src_restart = (take_src == SRC_EDGE) || (take_src == SRC_HI) || (take_src == SRC_LO);

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr && !mask_wdata[WB_MASK_EN] |=> $stable(mask_q)); // R2

  AST_NMI_LEVEL_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) && take_src == SRC_NMI |-> $past(nmi_in)); // R6

  AST_RESTART_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) && src_restart |-> $past(ie_q)); // R7

  AST_EXT_FLAG_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (take_ext == (take_src == SRC_EXT))); // R9

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb && !accept_stb |=> $stable(take_valid)); // R10

  AST_IE_DROPS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_stb && take_valid && take_src != SRC_NMI |=> !ie_q); // R11

  AST_VALID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_stb && take_valid |=> !take_valid); // R12

endmodule

bind ivc ivc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nmi_in     (nmi_in),
  .sample_stb (sample_stb),
  .accept_stb (accept_stb),
  .mask_wr    (mask_wr),
  .mask_wdata (mask_wdata),
  .take_valid (take_valid),
  .take_src   (take_src),
  .take_ext   (take_ext),
  .ie_q       (ie_q),
  .mask_q     (mask_q)
);

// File: tb/ivc_bench.sv
`timescale 1ns/1ps
module ivc_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_in = 0, edge_irq_in = 0, hi_irq_in = 0, lo_irq_in = 0, ext_irq_in = 0;
  logic        en_stb = 0, dis_stb = 0, sample_stb = 0, accept_stb = 0, mask_wr = 0;
  logic [7:0]  mask_wdata = 0;
  logic        ser_in = 0;
  logic [7:0]  stat_rdata;
  logic        ser_out, take_valid, take_ext;
  logic [2:0]  take_src;
  logic [15:0] take_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        valid;
    logic [2:0]  src;
    logic [15:0] vec;
    logic        ext;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;

  ivc u_ivc (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .edge_irq_in(edge_irq_in),
    .hi_irq_in(hi_irq_in), .lo_irq_in(lo_irq_in), .ext_irq_in(ext_irq_in),
    .en_stb(en_stb), .dis_stb(dis_stb), .sample_stb(sample_stb), .accept_stb(accept_stb),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .ser_in(ser_in), .stat_rdata(stat_rdata),
    .ser_out(ser_out), .take_valid(take_valid), .take_src(take_src),
    .take_vector(take_vector), .take_ext(take_ext)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sample_exp(input logic v, input logic [2:0] s, input logic [15:0] vec,
                            input logic e, input string tag);
    exp_t it;
    it.valid = v; it.src = s; it.vec = vec; it.ext = e; it.tag = tag;
    expq.push_back(it);
    sample_stb = 1'b1;
    tick();
    sample_stb = 1'b0;
  endtask

  task automatic do_accept(input string tag);
    accept_stb = 1'b1;
    tick();
    accept_stb = 1'b0;
    chk({tag, " valid after accept"}, {15'd0, take_valid}, 16'd0);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    mask_wr = 1'b1; mask_wdata = d;
    tick();
    mask_wr = 1'b0; mask_wdata = 8'h00;
  endtask

  task automatic pulse_en();
    en_stb = 1'b1; tick(); en_stb = 1'b0;
  endtask

  task automatic pulse_dis();
    dis_stb = 1'b1; tick(); dis_stb = 1'b0;
  endtask

  task automatic edge_pulse();
    edge_irq_in = 1'b1; tick();
    edge_irq_in = 1'b0; tick();
  endtask

  // monitor: pops one expected item per effective sample edge
  initial begin
    forever begin
      @(posedge clk);
      if (sample_stb && !accept_stb) begin
        @(negedge clk);
        if (expq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected sample actual=none expected=queued");
        end else begin
          exp_t it;
          it = expq.pop_front();
          chk({it.tag, " valid"}, {15'd0, take_valid}, {15'd0, it.valid});
          if (it.valid) begin
            chk({it.tag, " src"}, {13'd0, take_src}, {13'd0, it.src});
            chk({it.tag, " vector"}, take_vector, it.vec);
            chk({it.tag, " ext"}, {15'd0, take_ext}, {15'd0, it.ext});
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 / R4 reset state: masks 111, enable 0
    chk("R1 status", {8'd0, stat_rdata}, 16'h0007);
    chk("R1 take_valid", {15'd0, take_valid}, 16'd0);
    chk("R1 ser_out", {15'd0, ser_out}, 16'd0);

    pulse_en();
    chk("R11 enable set", {8'd0, stat_rdata}, 16'h000F);

    // R7 masked low line does not win; R4 level pending in bit 4
    lo_irq_in = 1'b1;
    tick();
    chk("R4 low pending", {8'd0, stat_rdata}, 16'h001F);
    sample_exp(1'b0, 3'd0, 16'h0, 1'b0, "R7 masked low");

    // R2 unmask all
    wr_ctrl(8'h08);
    chk("R2 masks loaded", {8'd0, stat_rdata}, 16'h0018);
    sample_exp(1'b1, 3'd4, 16'h002C, 1'b0, "R9 low vector");
    do_accept("R12 low");
    chk("R11 enable cleared by accept", {8'd0, stat_rdata}, 16'h0010);
    sample_exp(1'b0, 3'd0, 16'h0, 1'b0, "R7 enable off");

    // R8 high over low
    pulse_en();
    hi_irq_in = 1'b1;
    tick();
    sample_exp(1'b1, 3'd3, 16'h0034, 1'b0, "R8 high over low");
    do_accept("R12 high");
    hi_irq_in = 1'b0; lo_irq_in = 1'b0;

    // R10 level request gone before the sample leaves nothing
    pulse_en();
    lo_irq_in = 1'b1; tick();
    lo_irq_in = 1'b0; tick();
    sample_exp(1'b0, 3'd0, 16'h0, 1'b0, "R10 level gone");

    // R5 edge latch survives the input falling
    edge_pulse();
    chk("R5 edge latched", {8'd0, stat_rdata}, 16'h0048);
    sample_exp(1'b1, 3'd2, 16'h003C, 1'b0, "R5 edge vector");
    do_accept("R12 edge");
    chk("R12 edge latch consumed", {8'd0, stat_rdata}, 16'h0000);

    // R3 clear bit; R2 bit 3 low keeps masks
    edge_pulse();
    chk("R5 edge latched again", {8'd0, stat_rdata}, 16'h0040);
    wr_ctrl(8'h37);
    chk("R3 edge clear, R2 masks kept", {8'd0, stat_rdata}, 16'h0000);

    // R7 general request ignores masks, needs enable
    wr_ctrl(8'h0F);
    pulse_en();
    chk("R2 all masked", {8'd0, stat_rdata}, 16'h000F);
    ext_irq_in = 1'b1;
    tick();
    sample_exp(1'b1, 3'd5, 16'h0000, 1'b1, "R7 general unmasked");
    do_accept("R12 general");
    sample_exp(1'b0, 3'd0, 16'h0, 1'b0, "R7 general gated");
    ext_irq_in = 1'b0;

    // R8 non-maskable over edge; R11 accept keeps enable
    wr_ctrl(8'h08);
    pulse_en();
    edge_pulse();
    nmi_in = 1'b1;
    tick();
    sample_exp(1'b1, 3'd1, 16'h0024, 1'b0, "R8 nmi over edge");
    do_accept("R12 nmi");
    chk("R11 nmi accept keeps enable", {8'd0, stat_rdata}, 16'h0048);
    sample_exp(1'b1, 3'd2, 16'h003C, 1'b0, "R6 held nmi no repeat");
    do_accept("R12 edge after nmi");
    nmi_in = 1'b0;

    // R6 ignores enable and masks
    wr_ctrl(8'h0F);
    pulse_dis();
    chk("R11 disabled", {8'd0, stat_rdata}, 16'h0007);
    nmi_in = 1'b1; tick();
    sample_exp(1'b1, 3'd1, 16'h0024, 1'b0, "R6 nmi ignores gating");
    do_accept("R12 nmi masked");
    nmi_in = 1'b0; tick();
    nmi_in = 1'b1; tick();
    nmi_in = 1'b0;
    sample_exp(1'b0, 3'd0, 16'h0, 1'b0, "R6 nmi fell before sample");

    // R3 serial bit
    wr_ctrl(8'h80);
    chk("R3 serial needs enable", {15'd0, ser_out}, 16'd0);
    wr_ctrl(8'hC0);
    chk("R3 serial copied", {15'd0, ser_out}, 16'd1);
    ser_in = 1'b1; tick();
    chk("R4 serial in bit 7", {8'd0, stat_rdata}, 16'h0087);

    repeat (2) tick();
    chk("R10 queue drained", 16'(expq.size()), 16'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule